// File: doc/BRIEF.md
# Early-Termination Iterative Integer Divider

This block divides two 32-bit integers, signed or unsigned, one quotient bit per clock. Before the loop starts it takes the absolute value of the dividend and counts its leading zeros. It then runs only as many shift-subtract steps as the dividend has significant bits. A small dividend therefore finishes in a few cycles, and a full-width dividend takes the longest. After the loop a final cycle corrects the signs of the quotient and remainder. The block reports how many cycles it was busy, so that a pipeline controller can hold the stage that waits for the result.

Operands enter on a valid/ready handshake. `in_ready` is high exactly when the unit is idle, and an operand set is taken on a clock edge where both `in_valid` and `in_ready` are high. The result side has no back-pressure. The unit raises `done` for a single cycle, and the consumer must sample the results then or later. The results stay unchanged until the next `done`.

A divisor of zero does not run the loop. It raises a flag, returns an all-ones quotient and a remainder equal to the dividend, and takes the minimum time.

Top module: `ediv_core`

## Requirements
- R1: `in_ready` is high whenever `busy` is low. An operand set is taken on an edge where `in_valid` and `in_ready` are both high, and `busy` is high in the following cycle.
- R2: While `busy` is high, `in_valid` and the operand inputs have no effect. The running divide returns its own results, and no extra `done` follows.
- R3: For a nonzero divisor, `busy` stays high for 34 − lz cycles. Here lz is the leading-zero count of the dividend's magnitude: the two's-complement absolute value in signed mode, the raw value in unsigned mode. The maximum of 34 cycles is reached for a magnitude with bit 31 set, which includes the most negative value.
- R4: In unsigned mode (`in_signed` = 0) the quotient is floor(dividend / divisor) and the remainder is dividend mod divisor.
- R5: In signed mode (`in_signed` = 1) the quotient magnitude is truncated. The quotient is negated when the operand signs differ, and the remainder takes the dividend's sign. −2^31 / −1 returns 0x80000000 with remainder 0.
- R6: A zero dividend with a nonzero divisor finishes in 2 busy cycles with quotient 0 and remainder 0.
- R7: A zero divisor sets `div_by_zero`, returns quotient 0xFFFFFFFF and remainder equal to the dividend, and takes 2 busy cycles. `div_by_zero` is 0 for every other divide.
- R8: `done` is high for exactly one cycle: the cycle after the last busy cycle. `quotient`, `remainder`, `div_by_zero` and `cycles` change only together with `done`. `cycles` equals the number of busy cycles of that divide.
- R9: A new operand set offered while `done` is high is accepted in that same cycle.
- R10: After reset, `busy`, `done`, `div_by_zero`, `quotient`, `remainder` and `cycles` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit idle and able to take operands |
| in_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| in_dividend | input | 32 | Dividend |
| in_divisor | input | 32 | Divisor |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle result pulse |
| quotient | output | 32 | Quotient of the last divide |
| remainder | output | 32 | Remainder of the last divide |
| div_by_zero | output | 1 | Last divide had a zero divisor |
| cycles | output | 6 | Busy cycles used by the last divide |

## Verification
Two functions can fall in the same cycle: the result pulse of one divide and the acceptance of the next. The bench provokes this by keeping `in_valid` high with a second operand set across the first divide. It checks that the first results are correct in the `done` cycle and that `busy` is high on the very next cycle. It then checks that the second divide completes with its own results and cycle count. In a separate case, operands offered during a long divide are shown to change neither the running divide's results nor the number of `done` pulses.

// File: rtl/ediv_pkg.sv
package ediv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_ITER = 2'd2,
    ST_FIN  = 2'd3
  } ediv_state_e;
endpackage

// File: rtl/ediv_lzc.sv
// Leading-zero counter built from a prefix-OR chain.
module ediv_lzc #(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] lz
);
  logic [W-1:0] seen;  // seen[i]: some bit at or above i is set

  assign seen[W-1] = val[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_chain
    assign seen[i] = seen[i+1] | val[i];
  end

  always_comb begin
    lz = '0;
    for (int i = 0; i < W; i++) begin
      lz = lz + CW'(~seen[i]);
    end
  end
endmodule

// File: rtl/ediv_sign_prep.sv
// Absolute value and sign of one operand.
module ediv_sign_prep #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] raw,
  input  logic         is_signed,
  output logic [W-1:0] mag,
  output logic         neg
);
  assign neg = is_signed & raw[W-1];
  assign mag = neg ? (~raw + W'(1)) : raw;
endmodule

// File: rtl/ediv_step.sv
// One restoring shift-subtract step.
module ediv_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] quo_in,
  input  logic [W-1:0] dvsr,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] quo_out
);
  logic [W:0] trial;
  logic [W:0] diff;
  logic       fits;

  assign trial   = {rem_in, quo_in[W-1]};
  assign diff    = trial - {1'b0, dvsr};
  assign fits    = trial >= {1'b0, dvsr};
  assign rem_out = fits ? diff[W-1:0] : trial[W-1:0];
  assign quo_out = {quo_in[W-2:0], fits};
endmodule

// File: rtl/ediv_core.sv
module ediv_core #(
  parameter int unsigned DW   = 32,
  parameter int unsigned CW   = $clog2(DW + 1),
  parameter int unsigned CNTW = $clog2(DW + 3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_signed,
  input  logic [DW-1:0]   in_dividend,
  input  logic [DW-1:0]   in_divisor,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   quotient,
  output logic [DW-1:0]   remainder,
  output logic            div_by_zero,
  output logic [CNTW-1:0] cycles
);
  import ediv_pkg::*;

  ediv_state_e     state;
  logic [DW-1:0]   a_raw, b_raw;
  logic            sgn_r;
  logic [DW-1:0]   rem_q, quo_q, b_mag;
  logic [CW-1:0]   iter_left;
  logic            neg_q, neg_r, dz_r;
  logic [CNTW-1:0] busy_cnt;

  logic [DW-1:0]   a_mag_c, b_mag_c;
  logic            a_neg_c, b_neg_c;
  logic [CW-1:0]   lz_c;
  logic [CW-1:0]   sig_bits;
  logic [DW-1:0]   rem_nx, quo_nx;
  logic [DW-1:0]   q_fin, r_fin;
  logic            accept;

  assign busy     = (state != ST_IDLE);
  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  ediv_sign_prep #(.W(DW)) u_prep_a (
    .raw(a_raw), .is_signed(sgn_r), .mag(a_mag_c), .neg(a_neg_c)
  );
  ediv_sign_prep #(.W(DW)) u_prep_b (
    .raw(b_raw), .is_signed(sgn_r), .mag(b_mag_c), .neg(b_neg_c)
  );
  ediv_lzc #(.W(DW), .CW(CW)) u_lzc (
    .val(a_mag_c), .lz(lz_c)
  );
  ediv_step #(.W(DW)) u_step (
    .rem_in(rem_q), .quo_in(quo_q), .dvsr(b_mag),
    .rem_out(rem_nx), .quo_out(quo_nx)
  );

  assign sig_bits = CW'(DW) - lz_c;

  always_comb begin
    if (dz_r) begin
      q_fin = '1;
      r_fin = a_raw;
    end else begin
      q_fin = neg_q ? (~quo_q + DW'(1)) : quo_q;
      r_fin = neg_r ? (~rem_q + DW'(1)) : rem_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      a_raw       <= '0;
      b_raw       <= '0;
      sgn_r       <= 1'b0;
      rem_q       <= '0;
      quo_q       <= '0;
      b_mag       <= '0;
      iter_left   <= '0;
      neg_q       <= 1'b0;
      neg_r       <= 1'b0;
      dz_r        <= 1'b0;
      busy_cnt    <= '0;
      done        <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
      cycles      <= '0;
    end else begin
      done <= 1'b0;
      if (busy) busy_cnt <= busy_cnt + CNTW'(1);
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            a_raw    <= in_dividend;
            b_raw    <= in_divisor;
            sgn_r    <= in_signed;
            busy_cnt <= '0;
            state    <= ST_PREP;
          end
        end
        ST_PREP: begin
          rem_q     <= '0;
          quo_q     <= (lz_c >= CW'(DW)) ? '0 : (a_mag_c << lz_c);
          b_mag     <= b_mag_c;
          iter_left <= sig_bits;
          neg_q     <= a_neg_c ^ b_neg_c;
          neg_r     <= a_neg_c;
          dz_r      <= (b_raw == '0);
          if ((b_raw == '0) || (sig_bits == '0)) state <= ST_FIN;
          else                                   state <= ST_ITER;
        end
        ST_ITER: begin
          rem_q     <= rem_nx;
          quo_q     <= quo_nx;
          iter_left <= iter_left - CW'(1);
          if (iter_left == CW'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          quotient    <= q_fin;
          remainder   <= r_fin;
          div_by_zero <= dz_r;
          cycles      <= busy_cnt + CNTW'(1);
          done        <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy); // R1
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(a_raw) && $stable(b_raw)); // R2
  AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt <= CNTW'(DW + 1))); // R3
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ITER) |=> (rem_q < b_mag)); // R4
  AST_ZERO_DIVIDEND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero && cycles == CNTW'(2)) |-> (quotient == '0 && remainder == '0)); // R6
  AST_DZ_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (cycles == CNTW'(2) && quotient == '1)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy || $past(state) == ST_FIN) && $past(busy)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || ($stable(quotient) && $stable(remainder) && $stable(cycles)))); // R8
endmodule

// File: tb/ediv_core_tb.sv
module ediv_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_signed = 1'b0;
  logic [31:0] in_dividend = '0;
  logic [31:0] in_divisor = '0;
  logic        busy, done, div_by_zero;
  logic [31:0] quotient, remainder;
  logic [5:0]  cycles;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ediv_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_signed(in_signed), .in_dividend(in_dividend), .in_divisor(in_divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .div_by_zero(div_by_zero), .cycles(cycles)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic int lead_zeros(input logic [31:0] v);
    int z = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) break;
      z++;
    end
    return z;
  endfunction

  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic s,
                       output logic [31:0] q, output logic [31:0] r,
                       output logic dz, output int n);
    logic [31:0] ma, mb, mq, mr;
    logic na, nb;
    na = s && a[31];
    nb = s && b[31];
    ma = na ? -a : a;
    mb = nb ? -b : b;
    if (b == 0) begin
      dz = 1; q = 32'hFFFF_FFFF; r = a; n = 2;
    end else begin
      dz = 0;
      mq = ma / mb;
      mr = ma % mb;
      q = (na ^ nb) ? -mq : mq;
      r = na ? -mr : mr;
      n = 34 - lead_zeros(ma);
    end
  endtask

  // Wait for done counting busy cycles; returns at the negedge where done is seen.
  task automatic wait_done(output int nb);
    nb = 0;
    for (int k = 0; k < 100; k++) begin
      if (done) return;
      if (busy) nb++;
      @(negedge clk);
    end
  endtask

  task automatic judge(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic s, input int nb);
    logic [31:0] q, r;
    logic dz;
    int n;
    model(a, b, s, q, r, dz, n);
    chk("R8", "done seen", {31'd0, done}, 32'd1);
    chk(req, "quotient", quotient, q);
    chk(req, "remainder", remainder, r);
    chk("R7", "div_by_zero", {31'd0, div_by_zero}, {31'd0, dz});
    chk("R3", "busy cycles", nb, n);
    chk("R8", "cycles port", {26'd0, cycles}, nb);
  endtask

  task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                       input string req, input bit poke);
    int nb;
    @(negedge clk);
    in_valid = 1; in_dividend = a; in_divisor = b; in_signed = s;
    for (int k = 0; k < 100 && !in_ready; k++) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R1", "busy/ready after accept", {30'd0, busy, in_ready}, 32'd2);
    if (poke) begin
      in_valid = 1; in_dividend = 32'd5; in_divisor = 32'd1; in_signed = 0;
      repeat (3) @(negedge clk);
      in_valid = 0;
      chk("R2", "still busy during poke", {31'd0, busy}, 32'd1);
      wait_done(nb);
      nb += 3;
    end else begin
      wait_done(nb);
    end
    judge(req, a, b, s, nb);
    @(negedge clk);
    chk("R8", "done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int nb, quiet;
    logic [31:0] a, b;
    void'($urandom(32'd2468));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "busy", {31'd0, busy}, 0);
    chk("R10", "done", {31'd0, done}, 0);
    chk("R10", "in_ready", {31'd0, in_ready}, 1);
    chk("R10", "outputs", quotient | remainder | {26'd0, cycles} | {31'd0, div_by_zero}, 0);
    rst_n = 1;
    @(negedge clk);

    // directed corners
    do_op(32'd100, 32'd7, 0, "R4", 0);
    do_op(32'hFFFF_FFFF, 32'd3, 0, "R4", 0);
    do_op(32'd1, 32'd1, 0, "R4", 0);
    do_op(32'd0, 32'd9, 0, "R6", 0);
    do_op(32'd0, 32'd9, 1, "R6", 0);
    do_op(32'd1234, 32'd0, 0, "R7", 0);
    do_op(32'hFFFF_FF85, 32'd0, 1, "R7", 0);
    do_op(32'h8000_0000, 32'hFFFF_FFFF, 1, "R5", 0);
    do_op(32'h8000_0000, 32'd3, 1, "R5", 0);
    do_op(-32'sd100, 32'd7, 1, "R5", 0);
    do_op(32'd100, -32'sd7, 1, "R5", 0);
    do_op(-32'sd100, -32'sd7, 1, "R5", 0);
    do_op(32'h0001_0000, 32'h0002_0000, 0, "R4", 0);

    // R2: offers while busy are ignored
    do_op(32'hFFFF_FFFF, 32'd7, 0, "R2", 1);
    quiet = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done || busy) quiet++;
    end
    chk("R2", "no extra divide", quiet, 0);

    // R9: accept of the next divide in the done cycle
    @(negedge clk);
    in_valid = 1; in_dividend = 32'h7FFF_0000; in_divisor = 32'd13; in_signed = 0;
    @(negedge clk);
    in_dividend = -32'sd77; in_divisor = 32'd5; in_signed = 1;
    @(negedge clk);
    wait_done(nb);
    judge("R9", 32'h7FFF_0000, 32'd13, 0, nb + 1);
    @(negedge clk);
    in_valid = 0;
    chk("R9", "next divide accepted in done cycle", {31'd0, busy}, 32'd1);
    chk("R8", "done one cycle", {31'd0, done}, 32'd0);
    wait_done(nb);
    judge("R9", -32'sd77, 32'd5, 1, nb);

    // random mix
    for (int t = 0; t < 200; t++) begin
      a = $urandom() >> ($urandom() % 33);
      b = $urandom() >> ($urandom() % 32);
      if (($urandom() % 16) == 0) b = 0;
      do_op(a, b, 1'($urandom() % 2), ((t % 2) == 0) ? "R4" : "R5", 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule